// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block is the 8-bit arithmetic and logic stage of an accumulator-based processor, together with the condition-flag register that stage keeps. A request carries an operation code, the accumulator value and a second operand. The second operand is copied into a private temporary register that software cannot reach. The block then computes the result and updates the sign, zero, half-carry, parity and carry flags. Which flags change depends on the class of the operation. The five flags are always visible as one packed status byte.

A small sequencer runs each request. It has three states. In `ST_IDLE`, a `start` pulse captures the operation code, the accumulator value and the operand, and the transition `idle->exec` is taken. `ST_EXEC` evaluates the operation, registers the result and the flags, and always takes `exec->done`. `ST_DONE` shows `done` for one cycle, pulses `acc_we` when the result is meant for the accumulator, and always takes `done->idle`. The carry used by add-with-carry and subtract-with-borrow is the CY bit held in the status register.

Top module: `alu_flag_unit`

## Requirements
- R1: While reset is held (`rst_n` low, asynchronous), `status` reads 0x02, `result` reads 0x00, and `busy`, `done` and `acc_we` are all 0.
- R2: A `start` is accepted only in the idle state, and the inputs are captured at that edge. `busy` is 1 for the next two cycles. `done` is 1 in the second of those cycles, and new `result` and `status` values appear in the same cycle. A `start` given while `busy` is 1 is ignored.
- R3: The operation codes are 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 XOR, 6 OR, 7 CMP, 8 INC, 9 DEC. The result is the low 8 bits of A+B, A+B+CY, A−B, A−B−CY, A&B, A^B, A|B, A−B, A+1 and A−1 respectively.
- R4: The status byte is packed as bit7 S, bit6 Z, bit4 AC, bit2 P, bit0 CY. Bits 5 and 3 read 0 and bit 1 reads 1.
- R5: For codes 0–9, S equals bit 7 of the result, and Z is 1 exactly when the 8-bit result is zero.
- R6: For codes 0–9, P is 1 when the result holds an even number of 1 bits, and 0 when the count is odd.
- R7: AC is the carry out of bit 3 of the internal addition. ADD adds A+B, and ADC adds A+B+CY. SUB and CMP add A+~B+1, and SBB adds A+~B+(1−CY). INC adds A+1, and DEC adds A+0xFF.
- R8: On ADD and ADC, CY is the carry out of bit 7. On SUB, SBB and CMP, CY is 1 when a borrow occurs, meaning A is less than B (B+CY for SBB).
- R9: CMP updates every flag as SUB does, but `acc_we` stays 0 in its `done` cycle. Every other code from 0 to 9 pulses `acc_we` with `done`.
- R10: INC and DEC update S, Z, AC and P and leave CY unchanged.
- R11: AND, OR and XOR clear CY. AND sets AC, and OR and XOR clear it.
- R12: Codes 10–15 leave all flags unchanged, return the accumulator value as `result`, and never pulse `acc_we`.
- R13: Flags persist between operations. ADC and SBB use the CY produced by the previous operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted in the idle state only |
| op_code | input | 4 | Operation code (see R3) |
| acc_in | input | 8 | Accumulator value (operand A) |
| opnd_in | input | 8 | Second operand (B), copied into the temporary register |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Result and flags are valid this cycle |
| acc_we | output | 1 | Write the result back to the accumulator |
| result | output | 8 | Operation result |
| status | output | 8 | Packed condition flags (see R4) |

## Verification
The assertions assume that `op_code`, `acc_in` and `opnd_in` matter only at the edge where `start` is accepted in the idle state. They also assume that the flag checks apply only to codes 0–9. Codes 10–15 are checked for leaving the status register unchanged. The stimulus drives new values on falling edges, so that every input is settled at the capturing edge. It pulses `start` at random, including while the block is busy, so that requests that must be ignored occur often. The codes it draws cover the whole 4-bit range, so the unused codes are exercised as well as the defined ones.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_ADC = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_SBB = 4'd3;
    localparam logic [3:0] OP_AND = 4'd4;
    localparam logic [3:0] OP_XOR = 4'd5;
    localparam logic [3:0] OP_OR  = 4'd6;
    localparam logic [3:0] OP_CMP = 4'd7;
    localparam logic [3:0] OP_INC = 4'd8;
    localparam logic [3:0] OP_DEC = 4'd9;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         half_c,
    output logic         carry
);
    localparam int H = W / 2;
    localparam int U = W - H;

    logic [H:0] lo;
    logic [U:0] hi;

    always_comb begin
        lo     = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
        hi     = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + {{U{1'b0}}, lo[H]};
        sum    = {hi[U-1:0], lo[H-1:0]};
        half_c = lo[H];
        carry  = hi[U];
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_flag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  flags_t       flags_in,
    output logic [W-1:0] res,
    output flags_t       flags_out,
    output logic         wr_acc
);
    logic [W-1:0] add_b;
    logic         add_c;
    logic [W-1:0] add_sum;
    logic         add_half;
    logic         add_carry;

    always_comb begin
        add_b = b;
        add_c = 1'b0;
        unique case (op)
            OP_ADC:                add_c = flags_in.cy;
            OP_SUB, OP_CMP: begin  add_b = ~b; add_c = 1'b1; end
            OP_SBB: begin          add_b = ~b; add_c = ~flags_in.cy; end
            OP_INC: begin          add_b = '0; add_c = 1'b1; end
            OP_DEC: begin          add_b = '1; add_c = 1'b0; end
            default: ;
        endcase
    end

    alu_adder #(.W(W)) u_adder (
        .a      (a),
        .b      (add_b),
        .cin    (add_c),
        .sum    (add_sum),
        .half_c (add_half),
        .carry  (add_carry)
    );

    always_comb begin
        res       = a;
        flags_out = flags_in;
        wr_acc    = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res          = add_sum;
                flags_out.ac = add_half;
                flags_out.cy = add_carry;
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                res          = add_sum;
                flags_out.ac = add_half;
                flags_out.cy = ~add_carry;
                wr_acc       = (op != OP_CMP);
            end
            OP_INC, OP_DEC: begin
                res          = add_sum;
                flags_out.ac = add_half;
            end
            OP_AND: begin
                res          = a & b;
                flags_out.ac = 1'b1;
                flags_out.cy = 1'b0;
            end
            OP_XOR: begin
                res          = a ^ b;
                flags_out.ac = 1'b0;
                flags_out.cy = 1'b0;
            end
            OP_OR: begin
                res          = a | b;
                flags_out.ac = 1'b0;
                flags_out.cy = 1'b0;
            end
            default: wr_acc = 1'b0;
        endcase
        if (op <= OP_DEC) begin
            flags_out.s = res[W-1];
            flags_out.z = ~|res;
            flags_out.p = ~^res;
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    output logic         busy,
    output logic         done,
    output logic         acc_we,
    output logic [W-1:0] result,
    output logic [7:0]   status
);
    seq_state_e   state_q, state_d;
    logic [3:0]   op_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] tmp_q;
    logic [W-1:0] res_q;
    logic         we_q;
    flags_t       flags_q;

    logic [W-1:0] core_res;
    flags_t       core_flags;
    logic         core_we;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    alu_core #(.W(W)) u_core (
        .op        (op_q),
        .a         (acc_q),
        .b         (tmp_q),
        .flags_in  (flags_q),
        .res       (core_res),
        .flags_out (core_flags),
        .wr_acc    (core_we)
    );

    // registered outputs and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            acc_q   <= '0;
            tmp_q   <= '0;
            res_q   <= '0;
            we_q    <= 1'b0;
            flags_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q  <= op_code;
                    acc_q <= acc_in;
                    tmp_q <= opnd_in;
                end
                ST_EXEC: begin
                    res_q   <= core_res;
                    flags_q <= core_flags;
                    we_q    <= core_we;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_DONE);
        acc_we = done & we_q;
        result = res_q;
        status = {flags_q.s, flags_q.z, 1'b0, flags_q.ac,
                  1'b0, flags_q.p, 1'b1, flags_q.cy};
    end
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         acc_we,
    input logic [3:0]   op_q,
    input logic [W-1:0] result,
    input logic [7:0]   status
);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 4'd7) |-> !acc_we);

    a_r10_incdec_keep_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == 4'd8 || op_q == 4'd9)) |-> (status[0] == $past(status[0])));

    a_r11_logic_clear_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q >= 4'd4 && op_q <= 4'd6) |-> !status[0]);

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q <= 4'd9) |-> (status[6] == (result == '0)));

    a_r6_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q <= 4'd9) |-> (status[2] == ($countones(result) % 2 == 0)));

    a_r12_unused_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q > 4'd9) |-> ($stable(status) && !acc_we));
endmodule

bind alu_flag_unit alu_flag_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .acc_we (acc_we),
    .op_q   (op_q),
    .result (result),
    .status (status)
);

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       busy, done, acc_we;
    logic [7:0] result, status;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit m_init = 0;

    always #5 clk = ~clk;

    alu_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .busy(busy), .done(done),
        .acc_we(acc_we), .result(result), .status(status)
    );

    // behavioural reference
    int m_phase, m_op, m_a, m_b, m_res, m_we;
    int f_s, f_z, f_ac, f_p, f_cy;

    function automatic int ones(input int v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += (v >> i) & 1;
        return c;
    endfunction

    task automatic model_exec();
        int sum;
        int nb;
        m_we = 1;
        case (m_op)
            0, 1: begin
                sum  = m_a + m_b + ((m_op == 1) ? f_cy : 0);
                f_ac = (((m_a & 15) + (m_b & 15) + ((m_op == 1) ? f_cy : 0)) > 15) ? 1 : 0;
                f_cy = (sum > 255) ? 1 : 0;
                m_res = sum & 255;
            end
            2, 3, 7: begin
                nb   = (m_op == 3) ? f_cy : 0;
                f_ac = (((m_a & 15) + ((~m_b) & 15) + 1 - nb) > 15) ? 1 : 0;
                f_cy = (m_a < m_b + nb) ? 1 : 0;
                m_res = (m_a - m_b - nb) & 255;
                if (m_op == 7) m_we = 0;
            end
            8: begin
                f_ac = ((m_a & 15) == 15) ? 1 : 0;
                m_res = (m_a + 1) & 255;
            end
            9: begin
                f_ac = ((m_a & 15) != 0) ? 1 : 0;
                m_res = (m_a + 255) & 255;
            end
            4: begin m_res = m_a & m_b; f_ac = 1; f_cy = 0; end
            5: begin m_res = m_a ^ m_b; f_ac = 0; f_cy = 0; end
            6: begin m_res = m_a | m_b; f_ac = 0; f_cy = 0; end
            default: begin m_res = m_a; m_we = 0; end
        endcase
        if (m_op <= 9) begin
            f_s = (m_res >> 7) & 1;
            f_z = (m_res == 0) ? 1 : 0;
            f_p = (ones(m_res) % 2 == 0) ? 1 : 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_op = 0; m_a = 0; m_b = 0; m_res = 0; m_we = 0;
            f_s = 0; f_z = 0; f_ac = 0; f_p = 0; f_cy = 0;
            m_init = 1;
        end else if (m_phase == 0) begin
            if (start) begin
                m_op = op_code; m_a = acc_in; m_b = opnd_in; m_phase = 1;
            end
        end else if (m_phase == 1) begin
            model_exec();
            m_phase = 2;
        end else begin
            m_phase = 0;
        end
    end

    function automatic string op_tag(input int op);
        case (op)
            0:    return "R3 R5 R6 R7 R8 ADD";
            1:    return "R3 R7 R8 R13 ADC";
            2:    return "R3 R7 R8 SUB";
            3:    return "R3 R7 R8 R13 SBB";
            4, 5, 6: return "R3 R11 logic";
            7:    return "R9 CMP";
            8, 9: return "R10 INC/DEC";
            default: return "R12 unused";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (m_init && !finished) begin
            if (!rst_n) begin
                check("R1 reset status", status, 8'h02);
                check("R1 reset result", result, 0);
                check("R1 reset busy/done/we", {busy, done, acc_we}, 0);
            end else begin
                int exp_st;
                exp_st = (f_s << 7) | (f_z << 6) | (f_ac << 4) | (f_p << 2) | 2 | f_cy;
                check("R2 busy", busy, (m_phase != 0) ? 1 : 0);
                check("R2 done", done, (m_phase == 2) ? 1 : 0);
                check({op_tag(m_op), " acc_we R9"}, acc_we, (m_phase == 2) ? m_we : 0);
                check({op_tag(m_op), " result"}, result, m_res);
                check({op_tag(m_op), " status"}, status, exp_st);
                check("R4 fixed bits", {status[5], status[3], status[1]}, 3'b001);
            end
        end
    end

    task automatic issue(input int op, input int a, input int b);
        @(negedge clk);
        start = 1'b1; op_code = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0];
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        issue(0, 8'h0F, 8'h01);   // R7 half carry
        issue(0, 8'hFF, 8'h01);   // R8 carry, R5 zero
        issue(1, 8'h10, 8'h20);   // R13 ADC with CY=1
        issue(2, 8'h00, 8'h01);   // R8 borrow
        issue(3, 8'h05, 8'h05);   // R13 SBB with borrow in
        issue(7, 8'h42, 8'h42);   // R9 compare equal
        issue(8, 8'hFF, 8'h00);   // R10 INC keeps CY
        issue(9, 8'h00, 8'h00);   // R10 DEC wraps
        issue(4, 8'hF0, 8'h3C);   // R11 AND
        issue(6, 8'h00, 8'h00);   // R11 OR zero
        issue(13, 8'h99, 8'h11);  // R12 unused code
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            start   = ($urandom_range(0, 1) == 1);
            op_code = 4'($urandom_range(0, 15));
            acc_in  = 8'($urandom_range(0, 255));
            opnd_in = 8'($urandom_range(0, 255));
        end
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule